// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, decides which one should be serviced, and tells a host processor about it. Each line can be detected on a rising transition or on a high level. Requests are held in a pending register, and serviced requests in an in-service register. A mask register keeps chosen lines from winning. Priority is fixed: line 0 is highest and line 7 is lowest. A pending request only raises the interrupt output if it outranks every request already in service.

The host talks to the block in two ways. The first is a byte-wide register bus with a select, a write strobe, a read strobe and a two-bit address. The second is an acknowledge input, which the host pulses twice. On the first pulse the block chooses the winner and moves it into service. On the second pulse it presents a vector byte: the upper five bits of a programmed base, with the three-bit level of the winner in the low bits.

A host that leaves the interrupt output unused can poll instead. It writes a poll command and then reads; that read acts as the acknowledge. Service ends either through an end-of-interrupt command or automatically when the second acknowledge pulse finishes.

The acknowledge controller is a state machine with three states:
- Idle. A pulse on `iack` moves it to AckGap; this is the take transition. A poll command moves it to PollArmed; this is the arm transition.
- AckGap, the wait between the two pulses. The next `iack` pulse issues the vector and returns it to Idle; this is the issue transition.
- PollArmed. The next bus read returns the poll byte, acknowledges, and returns it to Idle; this is the poll-read transition.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When trigger-select bit i is 0, a rising transition on `irq_in[i]` sets pending bit i. Keeping the input high does not set it again after an acknowledge clears it. A low input clears the pending bit.
- R2: When trigger-select bit i is 1, pending bit i follows the level of `irq_in[i]` one cycle later. If the input is still high when end of interrupt clears its in-service bit, `int_out` is asserted again.
- R3: A command write (address 0) with data bit 1 set, while in Idle, arms poll mode. The next bus read acts as an acknowledge: it sets the in-service bit of the winning request, if one exists, and returns to Idle.
- R4: The poll read returns bit 7 = 1 when a request was eligible, with bits 2:0 holding the winner's level. All other bits are 0, so the byte is 0x00 when nothing is eligible.
- R5: While poll mode is armed, input activity does not change the pending register. A rising transition that happens inside that window is lost.
- R6: If no request is eligible at the first acknowledge pulse, the vector carries level 7 and no in-service bit is set.
- R7: A command write with data bit 0 set clears the lowest-numbered set in-service bit.
- R8: When setup bit 0 (auto end-of-interrupt) is 1, the in-service bit set by the first acknowledge pulse is cleared on the second pulse.
- R9: Priority is fixed, with level 0 highest. A pending request is eligible only if its level is lower-numbered than every set in-service bit.
- R10: One cycle after the second acknowledge pulse, `vec_valid` is high for one cycle. At that time `vec_out` holds setup bits 7:3 followed by the 3-bit level that was latched on the first pulse.
- R11: A masked line (mask bit 1) still sets its pending bit but never wins. `int_out` is high exactly when some unmasked pending request is eligible.
- R12: Synchronous active-high reset clears the pending, in-service and mask registers, clears the trigger selects to edge mode, and leaves the state machine in Idle.
- R13: Register map. Writes: address 0 is the command (bit 0 end of interrupt, bit 1 poll), address 1 is the mask, address 2 is the trigger select, and address 3 is the setup (bits 7:3 vector base, bit 0 auto end-of-interrupt). Reads outside poll mode: address 0 returns pending, 1 returns in-service, 2 returns mask, and 3 returns trigger select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (the poll byte while poll mode is armed) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to the host |
| iack | input | 1 | Acknowledge pulse, one cycle wide |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector valid strobe |

## Verification
The assertions assume the following about the block's inputs:
- `iack` pulses are one cycle wide.
- A bus cycle never asserts read and write together.
- The host does not issue end of interrupt in the same cycle as an acknowledge pulse.

The stimulus keeps within these rules. Each bus access is a single one-cycle strobe, driven after a clock edge. Each acknowledge is a pair of separate one-cycle pulses. Commands are issued only after the vector has been collected.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned BUS_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK_GAP = 2'd1,
        ST_POLL    = 2'd2
    } ack_state_e;

    typedef enum logic [1:0] {
        RG_CMD   = 2'd0,
        RG_MASK  = 2'd1,
        RG_TRIG  = 2'd2,
        RG_SETUP = 2'd3
    } reg_sel_e;

    localparam int unsigned CMD_EOI_BIT   = 0;
    localparam int unsigned CMD_POLL_BIT  = 1;
    localparam int unsigned SETUP_AEOI_BIT = 0;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int unsigned N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] trig_lvl,
    input  logic             freeze,
    input  logic [N_IRQ-1:0] ack_clr,
    output logic [N_IRQ-1:0] irr
);

    logic [N_IRQ-1:0] irq_q;
    logic [N_IRQ-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_in;
    end

    assign rise = irq_in & ~irq_q;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                irr[i] <= 1'b0;
            end else if (freeze) begin
                // capture stopped; only an acknowledge may retire an edge request
                if (!trig_lvl[i] && ack_clr[i]) irr[i] <= 1'b0;
            end else if (trig_lvl[i]) begin
                irr[i] <= irq_in[i];
            end else if (!irq_in[i]) begin
                irr[i] <= 1'b0;
            end else if (ack_clr[i]) begin
                irr[i] <= 1'b0;
            end else if (rise[i]) begin
                irr[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
    parameter int unsigned N_IRQ = 8,
    localparam int unsigned LW   = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] irr,
    input  logic [N_IRQ-1:0] mask,
    input  logic [N_IRQ-1:0] isr,
    output logic             any_req,
    output logic [LW-1:0]    win_lvl,
    output logic             isr_any,
    output logic [LW-1:0]    isr_top
);

    logic [N_IRQ-1:0] preempt_ok;
    logic [N_IRQ-1:0] eligible;

    always_comb begin
        isr_any = 1'b0;
        isr_top = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (isr[i]) begin
                isr_any = 1'b1;
                isr_top = LW'(i);
            end
        end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_gate
        assign preempt_ok[i] = !isr_any || (LW'(i) < isr_top);
    end

    assign eligible = irr & ~mask & preempt_ok;

    always_comb begin
        any_req = 1'b0;
        win_lvl = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                any_req = 1'b1;
                win_lvl = LW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_IRQ = 8,
    localparam int unsigned LW   = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iack,
    input  logic              poll_cmd,
    input  logic              poll_rd,
    input  logic              eoi_cmd,
    input  logic              aeoi,
    input  logic [BUS_W-1:LW] base_hi,
    input  logic              any_req,
    input  logic [LW-1:0]     win_lvl,
    input  logic              isr_any,
    input  logic [LW-1:0]     isr_top,
    output logic [N_IRQ-1:0]  isr,
    output logic [N_IRQ-1:0]  ack_clr,
    output logic              poll_armed,
    output logic [BUS_W-1:0]  vec_out,
    output logic              vec_valid
);

    localparam logic [LW-1:0] LOWEST_LVL = LW'(N_IRQ - 1);

    ack_state_e state_q, state_d;
    logic [LW-1:0] served_lvl;
    logic          served_real;
    logic          take_first, issue_vec, poll_take, grant;
    logic [N_IRQ-1:0] set_vec, eoi_clr, auto_clr;

    assign take_first = (state_q == ST_IDLE)    && iack;
    assign issue_vec  = (state_q == ST_ACK_GAP) && iack;
    assign poll_take  = (state_q == ST_POLL)    && poll_rd;
    assign poll_armed = (state_q == ST_POLL);
    assign grant      = (take_first || poll_take) && any_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (iack)          state_d = ST_ACK_GAP;
                else if (poll_cmd) state_d = ST_POLL;
            end
            ST_ACK_GAP: if (iack)    state_d = ST_IDLE;
            ST_POLL:    if (poll_rd) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        set_vec  = '0;
        eoi_clr  = '0;
        auto_clr = '0;
        if (grant) set_vec[win_lvl] = 1'b1;
        if (eoi_cmd && isr_any) eoi_clr[isr_top] = 1'b1;
        if (issue_vec && aeoi && served_real) auto_clr[served_lvl] = 1'b1;
    end

    assign ack_clr = set_vec;

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= (isr & ~(eoi_clr | auto_clr)) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            served_lvl  <= '0;
            served_real <= 1'b0;
            vec_out     <= '0;
            vec_valid   <= 1'b0;
        end else begin
            vec_valid <= issue_vec;
            if (take_first) begin
                served_lvl  <= any_req ? win_lvl : LOWEST_LVL;
                served_real <= any_req;
            end
            if (issue_vec) vec_out <= {base_hi, served_lvl};
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_IRQ = 8,
    localparam int unsigned LW   = $clog2(N_IRQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N_IRQ-1:0]  irq_in,
    output logic              int_out,
    input  logic              iack,
    output logic [BUS_W-1:0]  vec_out,
    output logic              vec_valid
);

    logic wr_en, rd_en;
    reg_sel_e sel;
    logic [N_IRQ-1:0] mask_q, trig_q, irr, isr, ack_clr;
    logic [BUS_W-1:LW] base_q;
    logic aeoi_q, poll_armed, any_req, isr_any;
    logic [LW-1:0] win_lvl, isr_top;
    logic eoi_cmd, poll_cmd;
    logic [BUS_W-1:0] poll_byte;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && bus_rd && !bus_wr;
    assign sel   = reg_sel_e'(bus_addr);

    assign eoi_cmd  = wr_en && (sel == RG_CMD) && bus_wdata[CMD_EOI_BIT];
    assign poll_cmd = wr_en && (sel == RG_CMD) && bus_wdata[CMD_POLL_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            trig_q <= '0;
            base_q <= '0;
            aeoi_q <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                RG_CMD:   ;
                RG_MASK:  mask_q <= bus_wdata[N_IRQ-1:0];
                RG_TRIG:  trig_q <= bus_wdata[N_IRQ-1:0];
                RG_SETUP: begin
                    base_q <= bus_wdata[BUS_W-1:LW];
                    aeoi_q <= bus_wdata[SETUP_AEOI_BIT];
                end
                default:  ;
            endcase
        end
    end

    irq_req_capture #(.N_IRQ(N_IRQ)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .trig_lvl (trig_q),
        .freeze   (poll_armed),
        .ack_clr  (ack_clr),
        .irr      (irr)
    );

    irq_prio_resolve #(.N_IRQ(N_IRQ)) res_i (
        .irr     (irr),
        .mask    (mask_q),
        .isr     (isr),
        .any_req (any_req),
        .win_lvl (win_lvl),
        .isr_any (isr_any),
        .isr_top (isr_top)
    );

    irq_ack_fsm #(.N_IRQ(N_IRQ)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .iack       (iack),
        .poll_cmd   (poll_cmd),
        .poll_rd    (rd_en),
        .eoi_cmd    (eoi_cmd),
        .aeoi       (aeoi_q),
        .base_hi    (base_q),
        .any_req    (any_req),
        .win_lvl    (win_lvl),
        .isr_any    (isr_any),
        .isr_top    (isr_top),
        .isr        (isr),
        .ack_clr    (ack_clr),
        .poll_armed (poll_armed),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );

    assign int_out = any_req;

    always_comb begin
        poll_byte = '0;
        poll_byte[BUS_W-1] = any_req;
        poll_byte[LW-1:0]  = win_lvl;
    end

    always_comb begin
        if (poll_armed) begin
            bus_rdata = poll_byte;
        end else begin
            unique case (sel)
                RG_CMD:   bus_rdata = BUS_W'(irr);
                RG_MASK:  bus_rdata = BUS_W'(isr);
                RG_TRIG:  bus_rdata = BUS_W'(mask_q);
                RG_SETUP: bus_rdata = BUS_W'(trig_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int unsigned N_IRQ = 8,
    localparam int unsigned LW   = $clog2(N_IRQ)
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             iack,
    input logic [N_IRQ-1:0] irq_in,
    input logic             int_out,
    input logic             vec_valid,
    input logic [7:0]       vec_out,
    input logic [N_IRQ-1:0] irr,
    input logic [N_IRQ-1:0] isr,
    input logic [N_IRQ-1:0] mask_q,
    input logic [N_IRQ-1:0] trig_q,
    input logic [7:LW]      base_q,
    input logic             poll_armed
);

    logic rd_strobe, eoi_wr;
    assign rd_strobe = bus_sel && bus_rd && !bus_wr;
    assign eoi_wr    = bus_sel && bus_wr && (bus_addr == 2'd0) && bus_wdata[0];

    a_r11_masked_silent: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~mask_q) == '0) |-> !int_out);

    a_r5_poll_freeze: assert property (@(posedge clk) disable iff (rst)
        (poll_armed && !rd_strobe) |=> $stable(irr));

    a_r10_vec_base: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[7:LW] == base_q));

    a_r7_eoi_one_bit: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !iack && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (irr == '0 && isr == '0 && mask_q == '0 && trig_q == '0 && !poll_armed));

    for (genvar i = 0; i < N_IRQ; i++) begin : g_lvl
        a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
            (trig_q[i] && !poll_armed) |=> (irr[i] == $past(irq_in[i])));
    end

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_IRQ(N_IRQ)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .iack       (iack),
    .irq_in     (irq_in),
    .int_out    (int_out),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out),
    .irr        (irr),
    .isr        (isr),
    .mask_q     (mask_q),
    .trig_q     (trig_q),
    .base_q     (base_q),
    .poll_armed (poll_armed)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       iack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #5ns clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .int_out   (int_out),
        .iack      (iack),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each issued vector with the oldest expected one
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected vector", vec_out, 8'hxx);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, vec_out, it.v);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1ns;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1ns;
        d = bus_rdata;
        @(posedge clk);
        #1ns;
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
    endtask

    // driver: push the expected vector, then run the two-pulse sequence
    task automatic ack_seq(input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.v = exp; it.tag = tag;
        exp_q.push_back(it);
        pulse_ack();
        pulse_ack();
        @(negedge clk);
    endtask

    task automatic set_irq(input int idx, input logic val);
        @(negedge clk);
        irq_in[idx] = val;
        @(negedge clk);
    endtask

    task automatic check_int(input string tag, input logic exp);
        @(negedge clk);
        check(tag, {7'b0, int_out}, {7'b0, exp});
    endtask

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        #1ns rst = 1'b0;

        // R12 reset state, R13 read map
        bus_read(2'd0, rd); check("R12 pending after reset", rd, 8'h00);
        bus_read(2'd1, rd); check("R12 in-service after reset", rd, 8'h00);
        bus_read(2'd2, rd); check("R12 mask after reset", rd, 8'h00);
        bus_read(2'd3, rd); check("R12 trigger after reset", rd, 8'h00);
        check_int("R12 int_out after reset", 1'b0);

        bus_write(2'd3, 8'h40);   // R13 setup: base 0x40, no auto EOI

        // R1 edge request, R10 vector format
        set_irq(3, 1'b1);
        check_int("R1 edge raises int", 1'b1);
        ack_seq(8'h43, "R10 vector level 3");
        bus_read(2'd1, rd); check("R1 in-service after ack", rd, 8'h08);
        check_int("R1 held input no new request", 1'b0);
        bus_write(2'd0, 8'h01);
        check_int("R1 no second request after EOI", 1'b0);
        set_irq(3, 1'b0);

        // R2 level request
        bus_write(2'd2, 8'h20);
        set_irq(5, 1'b1);
        check_int("R2 level raises int", 1'b1);
        ack_seq(8'h45, "R2 vector level 5");
        check_int("R2 blocked while in service", 1'b0);
        bus_write(2'd0, 8'h01);
        check_int("R2 level still high re-asserts after EOI", 1'b1);
        set_irq(5, 1'b0);
        check_int("R2 dropped level clears", 1'b0);
        bus_write(2'd2, 8'h00);

        // R9 fixed priority and preemption
        @(negedge clk); irq_in[2] = 1'b1; irq_in[6] = 1'b1;
        check_int("R9 two requests", 1'b1);
        ack_seq(8'h42, "R9 level 2 wins");
        check_int("R9 lower level cannot preempt", 1'b0);
        bus_write(2'd0, 8'h01);
        check_int("R9 lower level after EOI", 1'b1);
        ack_seq(8'h46, "R9 level 6 next");
        bus_write(2'd0, 8'h01);
        bus_read(2'd1, rd); check("R7 EOI cleared in-service", rd, 8'h00);
        @(negedge clk); irq_in[2] = 1'b0; irq_in[6] = 1'b0;

        // R7 EOI clears the highest of two nested in-service bits
        set_irq(4, 1'b1);
        ack_seq(8'h44, "R7 outer level 4");
        set_irq(1, 1'b1);
        ack_seq(8'h41, "R7 nested level 1");
        bus_read(2'd1, rd); check("R7 nested in-service", rd, 8'h12);
        bus_write(2'd0, 8'h01);
        bus_read(2'd1, rd); check("R7 EOI clears level 1 only", rd, 8'h10);
        bus_write(2'd0, 8'h01);
        @(negedge clk); irq_in[4] = 1'b0; irq_in[1] = 1'b0;

        // R11 mask
        bus_write(2'd1, 8'h02);
        set_irq(1, 1'b1);
        check_int("R11 masked no int", 1'b0);
        bus_read(2'd0, rd); check("R11 masked still pending", rd, 8'h02);
        bus_write(2'd1, 8'h00);
        check_int("R11 unmasked int", 1'b1);
        ack_seq(8'h41, "R11 vector level 1");
        bus_write(2'd0, 8'h01);
        set_irq(1, 1'b0);

        // R6 request dropped before acknowledge
        set_irq(4, 1'b1);
        set_irq(4, 1'b0);
        ack_seq(8'h47, "R6 spurious level 7");
        bus_read(2'd1, rd); check("R6 no in-service bit", rd, 8'h00);

        // R8 automatic end of interrupt
        bus_write(2'd3, 8'h41);
        set_irq(0, 1'b1);
        ack_seq(8'h40, "R8 vector level 0");
        bus_read(2'd1, rd); check("R8 in-service auto cleared", rd, 8'h00);
        set_irq(0, 1'b0);
        bus_write(2'd3, 8'h40);

        // R3 R4 R5 poll
        set_irq(3, 1'b1);
        bus_write(2'd0, 8'h02);
        set_irq(1, 1'b1);         // inside freeze window
        bus_read(2'd0, rd); check("R4 poll byte level 3", rd, 8'h83);
        bus_read(2'd1, rd); check("R3 poll read sets in-service", rd, 8'h08);
        bus_read(2'd0, rd); check("R5 edge inside freeze lost", rd, 8'h00);
        check_int("R5 no int from lost edge", 1'b0);
        bus_write(2'd0, 8'h01);
        @(negedge clk); irq_in[3] = 1'b0; irq_in[1] = 1'b0;

        // R4 poll with nothing pending
        bus_write(2'd0, 8'h02);
        bus_read(2'd0, rd); check("R4 poll byte empty", rd, 8'h00);
        bus_read(2'd1, rd); check("R3 empty poll sets nothing", rd, 8'h00);
        bus_read(2'd3, rd); check("R13 trigger read after poll", rd, 8'h00);

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 vectors missing actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule